// File: doc/BRIEF.md
# Adaptive Loop-Gain Normalizer

This block keeps the bandwidth of a bang-bang digital phase-locked loop steady while oscillator gain and input jitter drift. Once per reference period it takes one sample pair: the training word that was injected into the oscillator tuning path, for which the oscillator's own quantization noise serves, and the one-bit early/late decision of the phase detector. An internal model holds delayed running sums of the training sequence and weights them with a bank of adaptive gains, `NTAPS` of them and 16 by default. The model therefore mimics the loop's integrating response to the training word. A least-mean-squares update steers the gains until the part of the training sequence that remains in the decision averages out to zero.

The sum of the learned gains is the loop-gain estimate. The decision is divided by that estimate in a restoring divider, and the quotient is the normalized error passed on to the loop filter. Because the filter then sees error divided by gain, the open-loop gain no longer depends on analog spread. All numbers are two's complement, and gains carry `FRAC` fraction bits.

Both the sample input and the result output use valid/ready. The input is accepted only while the block is idle. A result is held, unchanged, until the consumer takes it, and the next sample can be accepted in the cycle after that handshake. A consumer that keeps `out_ready` low therefore stalls the producer and loses nothing. `out_valid` doubles as the division-done flag.

Top module: `lgn_normalizer`

## Requirements
- R1: `in_ready` is 1 exactly when no job is in flight. A sample is taken only on a clock edge where both `in_valid` and `in_ready` are 1. While a job is in flight, `in_valid` and the input data are ignored and do not change any later result.
- R2: Once `out_valid` is 1, it stays 1 and `out_norm` and `out_gain` stay constant until a cycle in which `out_ready` is 1. `out_valid` falls on the next edge, and `in_ready` is 1 from that edge on.
- R3: `out_valid` rises on the 2·FRAC+1-th clock edge after the edge that accepts the sample.
- R4: History word d_k, for k = 0..NTAPS-1, is the running sum of all training words accepted before the current sample, taken k samples back. The current sample's training word only enters d_0 after the update. The sums wrap in AW-bit two's complement.
- R5: The residual is r = E − Σ g_k·d_k, where E = +2^FRAC when `in_err_neg` = 0 and E = −2^FRAC when `in_err_neg` = 1.
- R6: Each gain updates as g_k ← sat_GW(g_k + ((r·d_k) >>> s)), with an arithmetic shift. s is `step_shift` clamped to the range 4..16.
- R7: `out_gain` is the sum of the updated gains, saturated to GW bits, then raised to GMIN if it is below GMIN. It is never below GMIN.
- R8: `out_norm` = ±floor(2^(2·FRAC) / `out_gain`). The value is negative when `in_err_neg` = 1.
- R9: After reset, g_0 = 2^FRAC, every other gain is 0, every history word is 0, `in_ready` = 1 and `out_valid` = 0. A reset in mid-run clears all of these.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block idle, sample will be taken |
| in_train | input | TW | Signed training word injected into the oscillator |
| in_err_neg | input | 1 | Phase-detector decision: 1 means −1, 0 means +1 |
| step_shift | input | 5 | LMS step as a right shift, clamped to 4..16 |
| out_valid | output | 1 | Result held, doubles as the division-done flag |
| out_ready | input | 1 | Consumer takes the result |
| out_norm | output | 2·FRAC+2 | Signed normalized error |
| out_gain | output | GW | Signed loop-gain estimate used as the divisor |

## Verification
On every cycle, the assertions check the output handshake: the held result stays stable under back-pressure, a result never coexists with an open input, the divider latency is exact, the sign of `out_norm` follows the accepted decision, and the divisor floor holds. The adaptive arithmetic can only be shown by the bench's scenarios. These include the residual, the tap updates with step clamping and saturation, the wrapping history, the quotient value, samples poked in while busy being ignored, and the clearing of state by a mid-run reset. For all of these, the bench recomputes every result from the requirement formulas over sweeps of step shift, decision and training patterns.

// File: rtl/lgn_pkg.sv
package lgn_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_HOLD} lgn_state_e;

  localparam int unsigned STEP_LO = 4;
  localparam int unsigned STEP_HI = 16;

  function automatic logic [4:0] clamp_step(input logic [4:0] s);
    if (s < 5'(STEP_LO)) return 5'(STEP_LO);
    if (s > 5'(STEP_HI)) return 5'(STEP_HI);
    return s;
  endfunction
endpackage

// File: rtl/lgn_tap.sv
module lgn_tap #(
  parameter int GW   = 16,
  parameter int AW   = 12,
  parameter int RW   = 34,
  parameter int INIT = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd,
  input  logic signed [AW-1:0]     hist,
  input  logic signed [RW-1:0]     resid,
  input  logic [4:0]               step,
  output logic signed [GW-1:0]     gain_nx,
  output logic signed [GW+AW-1:0]  contrib
);
  localparam int PW = RW + AW;

  logic signed [GW-1:0] gain_q;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] delta;
  logic signed [PW:0]   trial;

  always_comb begin
    contrib = $signed({{AW{gain_q[GW-1]}}, gain_q}) * $signed({{GW{hist[AW-1]}}, hist});
    prod    = $signed({{AW{resid[RW-1]}}, resid}) * $signed({{RW{hist[AW-1]}}, hist});
    delta   = prod >>> step;
    trial   = {{(PW+1-GW){gain_q[GW-1]}}, gain_q} + {delta[PW-1], delta};
    if (trial[PW:GW-1] == {(PW-GW+2){trial[PW]}})
      gain_nx = trial[GW-1:0];
    else
      gain_nx = trial[PW] ? {1'b1, {(GW-1){1'b0}}} : {1'b0, {(GW-1){1'b1}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   gain_q <= GW'(INIT);
    else if (upd) gain_q <= gain_nx;
  end
endmodule

// File: rtl/lgn_divider.sv
module lgn_divider #(
  parameter int NW = 17,
  parameter int DW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          last,
  output logic [NW-1:0] quo
);
  localparam int CNTW = $clog2(NW + 1);

  logic [DW-1:0]   rem_q, den_q, rem_nx;
  logic [NW-1:0]   quo_q;
  logic [CNTW-1:0] cnt_q;
  logic [DW:0]     shifted;
  logic            ge;

  always_comb begin
    shifted = {rem_q, quo_q[NW-1]};
    ge      = shifted >= {1'b0, den_q};
    rem_nx  = ge ? DW'(shifted - {1'b0, den_q}) : shifted[DW-1:0];
  end

  assign last = (cnt_q == CNTW'(1));
  assign quo  = quo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      den_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
    end else if (start) begin
      rem_q <= '0;
      den_q <= den;
      quo_q <= num;
      cnt_q <= CNTW'(NW);
    end else if (cnt_q != '0) begin
      rem_q <= rem_nx;
      quo_q <= {quo_q[NW-2:0], ge};
      cnt_q <= cnt_q - CNTW'(1);
    end
  end
endmodule

// File: rtl/lgn_normalizer.sv
module lgn_normalizer
  import lgn_pkg::*;
#(
  parameter int TW    = 8,
  parameter int AW    = 12,
  parameter int GW    = 16,
  parameter int FRAC  = 8,
  parameter int NTAPS = 16,
  parameter int GMIN  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [TW-1:0]     in_train,
  input  logic                     in_err_neg,
  input  logic [4:0]               step_shift,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [2*FRAC+1:0] out_norm,
  output logic signed [GW-1:0]     out_gain
);
  localparam int LW  = $clog2(NTAPS) + 1;
  localparam int CW  = GW + AW;
  localparam int MW  = CW + LW;
  localparam int RW  = MW + 1;
  localparam int SW  = GW + LW;
  localparam int NW  = 2 * FRAC + 1;
  localparam int ONE = 1 << FRAC;
  localparam logic signed [GW-1:0] GMIN_W = GW'(GMIN);

  lgn_state_e st_q;
  logic fire, div_last, neg_q;
  logic [4:0] step_eff;
  logic signed [AW-1:0] hist_q   [NTAPS];
  logic signed [GW-1:0] gain_nx  [NTAPS];
  logic signed [CW-1:0] contrib  [NTAPS];
  logic signed [MW-1:0] model_sum;
  logic signed [RW-1:0] err_word, resid;
  logic signed [SW-1:0] gsum;
  logic signed [GW-1:0] gsat, gclamp, gain_q;
  logic [NW-1:0] quo;

  assign in_ready  = (st_q == ST_IDLE);
  assign out_valid = (st_q == ST_HOLD);
  assign fire      = in_valid && in_ready;
  assign step_eff  = clamp_step(step_shift);

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    lgn_tap #(
      .GW(GW), .AW(AW), .RW(RW), .INIT((k == 0) ? ONE : 0)
    ) u_tap (
      .clk(clk), .rst_n(rst_n), .upd(fire),
      .hist(hist_q[k]), .resid(resid), .step(step_eff),
      .gain_nx(gain_nx[k]), .contrib(contrib[k])
    );
  end

  always_comb begin
    model_sum = '0;
    gsum      = '0;
    for (int k = 0; k < NTAPS; k++) begin
      model_sum = model_sum + MW'(contrib[k]);
      gsum      = gsum + SW'(gain_nx[k]);
    end
    err_word = in_err_neg ? RW'(-ONE) : RW'(ONE);
    resid    = err_word - RW'(model_sum);
    if (gsum[SW-1:GW-1] == {(SW-GW+1){gsum[SW-1]}})
      gsat = gsum[GW-1:0];
    else
      gsat = gsum[SW-1] ? {1'b1, {(GW-1){1'b0}}} : {1'b0, {(GW-1){1'b1}}};
    gclamp = (gsat < GMIN_W) ? GMIN_W : gsat;
  end

  lgn_divider #(.NW(NW), .DW(GW-1)) u_div (
    .clk(clk), .rst_n(rst_n), .start(fire),
    .num({1'b1, {(2*FRAC){1'b0}}}), .den(gclamp[GW-2:0]),
    .last(div_last), .quo(quo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      neg_q  <= 1'b0;
      gain_q <= '0;
      for (int k = 0; k < NTAPS; k++) hist_q[k] <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (fire) begin
          st_q      <= ST_DIV;
          neg_q     <= in_err_neg;
          gain_q    <= gclamp;
          hist_q[0] <= hist_q[0] + AW'(in_train);
          for (int k = 1; k < NTAPS; k++) hist_q[k] <= hist_q[k-1];
        end
        ST_DIV:  if (div_last) st_q <= ST_HOLD;
        ST_HOLD: if (out_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign out_gain = gain_q;
  assign out_norm = neg_q ? -$signed({1'b0, quo}) : $signed({1'b0, quo});
endmodule

// File: rtl/lgn_normalizer_chk.sv
module lgn_normalizer_chk #(
  parameter int GW   = 16,
  parameter int FRAC = 8,
  parameter int GMIN = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic                     in_err_neg,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic signed [2*FRAC+1:0] out_norm,
  input logic signed [GW-1:0]     out_gain
);
  localparam int NW = 2 * FRAC + 1;

  logic [7:0] lat_q;
  logic       neg_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q   <= '0;
      neg_cap <= 1'b0;
    end else if (in_valid && in_ready) begin
      lat_q   <= 8'd1;
      neg_cap <= in_err_neg;
    end else if (lat_q != '0 && !out_valid) begin
      lat_q   <= lat_q + 8'd1;
    end
  end

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_norm) && $stable(out_gain));

  // R2
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> in_ready && !out_valid);

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> lat_q == 8'(NW + 1));

  // R7
  gain_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $signed(out_gain) >= GMIN);

  // R8
  norm_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_norm[2*FRAC+1] == neg_cap);
endmodule

bind lgn_normalizer lgn_normalizer_chk #(.GW(GW), .FRAC(FRAC), .GMIN(GMIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_err_neg(in_err_neg), .out_valid(out_valid), .out_ready(out_ready),
  .out_norm(out_norm), .out_gain(out_gain)
);

// File: tb/lgn_normalizer_bench.sv
module lgn_normalizer_bench;
  localparam int TW = 8, AW = 12, GW = 16, FRAC = 8, NT = 16, GMIN = 16;
  localparam int NW = 2 * FRAC + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_err_neg = 1'b0, out_ready = 1'b0;
  logic signed [TW-1:0] in_train = '0;
  logic [4:0] step_shift = 5'd8;
  logic in_ready, out_valid;
  logic signed [2*FRAC+1:0] out_norm;
  logic signed [GW-1:0] out_gain;

  int checks = 0, errors = 0, cycles = 0;
  bit seen_min = 1'b0;
  longint g [NT];
  longint h [NT];
  logic [15:0] lf = 16'hACE1;

  always #2 clk = ~clk;

  lgn_normalizer u_lgn_normalizer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_train(in_train), .in_err_neg(in_err_neg), .step_shift(step_shift),
    .out_valid(out_valid), .out_ready(out_ready), .out_norm(out_norm), .out_gain(out_gain)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint wrap_a(input longint x);
    longint m = x & ((64'sd1 <<< AW) - 1);
    return (m >= (64'sd1 <<< (AW - 1))) ? m - (64'sd1 <<< AW) : m;
  endfunction

  function automatic longint sat_g(input longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  function automatic logic [15:0] lfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic model_reset();
    for (int k = 0; k < NT; k++) begin g[k] = 0; h[k] = 0; end
    g[0] = 1 << FRAC;
  endtask

  // R4 R5 R6 R7 R8: reference arithmetic
  task automatic model(input int tr, input bit neg, input int sh,
                       output longint en, output longint eg);
    longint m = 0, r, gs = 0, gc, q;
    int s = (sh < 4) ? 4 : (sh > 16) ? 16 : sh;
    for (int k = 0; k < NT; k++) m += g[k] * h[k];
    r = (neg ? -(64'sd1 <<< FRAC) : (64'sd1 <<< FRAC)) - m;
    for (int k = 0; k < NT; k++) begin
      g[k] = sat_g(g[k] + ((r * h[k]) >>> s));
      gs += g[k];
    end
    gc = sat_g(gs);
    if (gc < GMIN) gc = GMIN;
    q  = (64'sd1 <<< (2 * FRAC)) / gc;
    en = neg ? -q : q;
    eg = gc;
    for (int k = NT - 1; k > 0; k--) h[k] = h[k-1];
    h[0] = wrap_a(h[0] + tr);
  endtask

  task automatic sample(input int tr, input bit neg, input int sh, input int stall, input bit poke);
    longint en, eg;
    longint n0;
    int cyc;
    model(tr, neg, sh, en, eg);
    @(negedge clk);
    chk(in_ready === 1'b1, "R1 idle ready", longint'(in_ready), 1);
    in_valid = 1'b1; in_train = TW'(tr); in_err_neg = neg; step_shift = 5'(sh);
    @(negedge clk);
    cyc = 1;
    if (poke) begin
      in_train = -8'sd100; in_err_neg = ~neg;  // R1: ignored while busy
      chk(in_ready === 1'b0, "R1 busy not ready", longint'(in_ready), 0);
    end else in_valid = 1'b0;
    while (!out_valid && cyc < 100) begin @(negedge clk); cyc++; end
    in_valid = 1'b0;
    chk(cyc == NW + 1, "R3 latency", cyc, NW + 1);
    chk(longint'(out_norm) == en, "R8 norm", longint'(out_norm), en);
    chk(longint'(out_gain) == eg, "R7 gain", longint'(out_gain), eg);
    if (eg == GMIN) seen_min = 1'b1;
    n0 = longint'(out_norm);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(out_valid && longint'(out_norm) == n0, "R2 hold", longint'(out_norm), n0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R2 release", longint'(out_valid), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R9 reset state", longint'(out_valid), 0);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    model_reset();
    do_reset();
    // R5 R6: mixed random patterns at a mid step
    for (int i = 0; i < 40; i++) begin
      lf = lfsr(lf);
      sample(int'($signed(lf[3:0])) / 2, lf[7], 6, i % 3, i % 4 == 1);
    end
    // R6: step sweep across and beyond the clamp range
    for (int sh = 0; sh < 22; sh++)
      for (int j = 0; j < 3; j++) begin
        lf = lfsr(lf);
        sample(int'($signed(lf[2:0])), lf[9], sh, 0, 1'b0);
      end
    // R4: large constant training forces wrap of the running sums
    do_reset();
    for (int i = 0; i < 40; i++) begin
      lf = lfsr(lf);
      sample(127, lf[5], 16, 0, i % 5 == 0);
    end
    // R9: mid-run reset clears history, then R7 floor case
    do_reset();
    sample(100, 1'b0, 4, 0, 1'b0);
    sample(0, 1'b1, 4, 1, 1'b0);
    chk(seen_min, "R7 floor reached", longint'(seen_min), 1);
    for (int i = 0; i < 30; i++) begin
      lf = lfsr(lf);
      sample(int'($signed(lf[4:0])), lf[11], 5, 0, 1'b1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule